// File: doc/BRIEF.md
# Residue-Quotient SAD Checker with Recovery

This block runs next to a row of motion-estimation processing elements. Each element computes a sum of absolute differences (SAD) over a 4x4 block of 8-bit current and reference pixels. The checker receives the same pixel stream as every element. For each element it builds a private reference SAD in a test code generator and keeps that SAD as a residue and quotient against modulus 64. A select input chooses one element. The SAD reported by that element is split into the same residue and quotient, and the two code pairs are compared bit by bit.

When the codes agree, the element's own value is passed on. When any code bit differs, the error flag goes high. That flag steers the output multiplexer to a value rebuilt from the test generator's quotient and residue. Detection and rebuilding happen in the same cycle. Each result is also tagged for its destination: it either goes on to the next element in the chain, or, for the last element, it is the final result.

A run starts with a pulse on `start_i`. Each pixel pair is then offered with `pix_valid_i`. The result appears for exactly one cycle, marked by `done_o`.

Top module: `rq_eddr`

## Requirements
- R1: After reset is released, `done_o`, `err_o`, `fwd_vld_o` and `fin_vld_o` are 0 and `data_o` is 0.
- R2: `done_o` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the 16th pixel pair of a run. Cycles with `pix_valid_i` low are not counted.
- R3: The test SAD for element e is the sum over the accepted pairs of |cur - ref|, taken as unsigned 8-bit values on lane e of `cur_pix_i` and `ref_pix_i`. Its largest value, 4080, fits in 12 bits.
- R4: The residue is SAD mod 64, which is bits 5:0. The quotient is SAD / 64, which is bits 11:6. While `done_o` is high, `err_o` is 1 exactly when the residue or the quotient of the selected element's reported SAD differs from that of the test SAD.
- R5: While `done_o` is high and `err_o` is 0, `data_o` equals the selected element's reported SAD.
- R6: While `done_o` is high and `err_o` is 1, `data_o` equals quotient x 64 + residue of the test SAD. That is the true SAD, for any set of stuck-at-0 and stuck-at-1 bits on the reported value.
- R7: `sel_i` chooses which lane of `pe_sad_i` is checked, and against which test generator. Faults on lanes that are not selected have no effect on `err_o` or `data_o`.
- R8: A `start_i` pulse clears every test accumulator and the pair count, and it drops any pair offered in the same cycle. A run can be restarted at any point. The next `done_o` then reflects only the pairs accepted after the last start.
- R9: While `done_o` is low, `err_o`, `data_o`, `fwd_vld_o` and `fin_vld_o` are all 0.
- R10: While `done_o` is high, `fin_vld_o` is 1 if `sel_i` equals NUM_PE-1 and `fwd_vld_o` is 1 otherwise. Never are both high at once.
- R11: Pixel pairs offered after the 16th pair of a run, or before the first start, are ignored and do not produce another `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a new run; clears the accumulators |
| pix_valid_i | input | 1 | A pixel pair is present on all lanes |
| cur_pix_i | input | NUM_PE x 8 | Current pixel, one lane per element |
| ref_pix_i | input | NUM_PE x 8 | Reference pixel, one lane per element |
| pe_sad_i | input | NUM_PE x 12 | SAD reported by each element under test |
| sel_i | input | SEL_W | Index of the element under test |
| done_o | output | 1 | Result valid, one cycle |
| err_o | output | 1 | 1 means the selected element's SAD is wrong |
| data_o | output | 12 | Element SAD, or the rebuilt SAD when in error |
| fwd_vld_o | output | 1 | Result goes to the next element |
| fin_vld_o | output | 1 | Result is the final output |

## Verification
The hardest case to reach is a fault that changes only the quotient, or only the residue. A second hard case is a stuck bit that happens to match the true bit, so the reported value stays correct and the flag must stay low. Random pixels rarely produce these cases on their own. The bench therefore draws stuck-at-0 and stuck-at-1 masks per lane, of single bits, of several bits, and of one low and one high bit together. It runs these masks on random blocks and on all-zero and all-maximum blocks. It derives the expected flag from whether the masked value differs from the true SAD. Runs with idle gaps between pairs, restarts partway through a block, and extra pairs after the 16th exercise the counting rules.

// File: rtl/eddr_pkg.sv
package eddr_pkg;
  localparam int DEF_NUM_PE = 4;
  localparam int DEF_PIX_W  = 8;
  localparam int DEF_N_PIX  = 16;
  localparam int DEF_MOD_W  = 6;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/eddr_rq_gen.sv
module eddr_rq_gen #(
  parameter int SAD_W = 12,
  parameter int MOD_W = 6,
  localparam int Q_W  = SAD_W - MOD_W
) (
  input  logic [SAD_W-1:0] sad_i,
  output logic [MOD_W-1:0] res_o,
  output logic [Q_W-1:0]   quo_o
);
  // modulus is 2**MOD_W: residue and quotient are plain bit fields
  assign res_o = sad_i[MOD_W-1:0];
  assign quo_o = sad_i[SAD_W-1:MOD_W];
endmodule

// File: rtl/eddr_tcg.sv
module eddr_tcg #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 12,
  parameter int MOD_W = 6,
  localparam int Q_W  = SAD_W - MOD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] ref_i,
  output logic [MOD_W-1:0] res_o,
  output logic [Q_W-1:0]   quo_o
);
  logic [PIX_W-1:0] diff;
  logic [SAD_W-1:0] acc_q;

  assign diff = (cur_i >= ref_i) ? (cur_i - ref_i) : (ref_i - cur_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + SAD_W'(diff);
  end

  eddr_rq_gen #(.SAD_W(SAD_W), .MOD_W(MOD_W)) i_rq (
    .sad_i(acc_q),
    .res_o(res_o),
    .quo_o(quo_o)
  );
endmodule

// File: rtl/eddr_check.sv
module eddr_check #(
  parameter int SAD_W = 12,
  parameter int MOD_W = 6,
  localparam int Q_W  = SAD_W - MOD_W
) (
  input  logic [MOD_W-1:0] rt_i,
  input  logic [Q_W-1:0]   qt_i,
  input  logic [MOD_W-1:0] rpe_i,
  input  logic [Q_W-1:0]   qpe_i,
  input  logic [SAD_W-1:0] pe_sad_i,
  output logic             err_o,
  output logic [SAD_W-1:0] data_o
);
  logic [SAD_W-1:0] rebuilt;

  // detection: any differing code bit
  assign err_o   = |{rt_i ^ rpe_i, qt_i ^ qpe_i};
  // recovery: quotient * 2**MOD_W + residue
  assign rebuilt = {qt_i, rt_i};
  assign data_o  = err_o ? rebuilt : pe_sad_i;
endmodule

// File: rtl/rq_eddr.sv
module rq_eddr
  import eddr_pkg::*;
#(
  parameter int NUM_PE = DEF_NUM_PE,
  parameter int PIX_W  = DEF_PIX_W,
  parameter int N_PIX  = DEF_N_PIX,
  parameter int MOD_W  = DEF_MOD_W,
  localparam int SAD_W = PIX_W + $clog2(N_PIX),
  localparam int Q_W   = SAD_W - MOD_W,
  localparam int SEL_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
  localparam int CNT_W = $clog2(N_PIX + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          pix_valid_i,
  input  logic [NUM_PE-1:0][PIX_W-1:0]  cur_pix_i,
  input  logic [NUM_PE-1:0][PIX_W-1:0]  ref_pix_i,
  input  logic [NUM_PE-1:0][SAD_W-1:0]  pe_sad_i,
  input  logic [SEL_W-1:0]              sel_i,
  output logic                          done_o,
  output logic                          err_o,
  output logic [SAD_W-1:0]              data_o,
  output logic                          fwd_vld_o,
  output logic                          fin_vld_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             accept;
  logic             last_pair;

  assign accept    = (phase_q == PH_RUN) && pix_valid_i && !start_i;
  assign last_pair = accept && (cnt_q == CNT_W'(N_PIX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_pair;
      if (start_i) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
      end else if (accept) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_pair) phase_q <= PH_IDLE;
      end
    end
  end

  logic [NUM_PE-1:0][MOD_W-1:0] rt_all;
  logic [NUM_PE-1:0][Q_W-1:0]   qt_all;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_tcg
    eddr_tcg #(.PIX_W(PIX_W), .SAD_W(SAD_W), .MOD_W(MOD_W)) i_tcg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .en_i  (accept),
      .cur_i (cur_pix_i[g]),
      .ref_i (ref_pix_i[g]),
      .res_o (rt_all[g]),
      .quo_o (qt_all[g])
    );
  end

  // element select; an out-of-range index reads lane 0
  logic [MOD_W-1:0] rt_sel;
  logic [Q_W-1:0]   qt_sel;
  logic [SAD_W-1:0] sad_sel;
  always_comb begin
    rt_sel  = rt_all[0];
    qt_sel  = qt_all[0];
    sad_sel = pe_sad_i[0];
    for (int i = 1; i < NUM_PE; i++) begin
      if (int'(sel_i) == i) begin
        rt_sel  = rt_all[i];
        qt_sel  = qt_all[i];
        sad_sel = pe_sad_i[i];
      end
    end
  end

  logic [MOD_W-1:0] rpe;
  logic [Q_W-1:0]   qpe;
  eddr_rq_gen #(.SAD_W(SAD_W), .MOD_W(MOD_W)) i_pe_rq (
    .sad_i(sad_sel),
    .res_o(rpe),
    .quo_o(qpe)
  );

  logic             cmp_err;
  logic [SAD_W-1:0] cmp_data;
  eddr_check #(.SAD_W(SAD_W), .MOD_W(MOD_W)) i_check (
    .rt_i    (rt_sel),
    .qt_i    (qt_sel),
    .rpe_i   (rpe),
    .qpe_i   (qpe),
    .pe_sad_i(sad_sel),
    .err_o   (cmp_err),
    .data_o  (cmp_data)
  );

  logic is_last;
  assign is_last = (int'(sel_i) == NUM_PE - 1);

  assign done_o    = done_q;
  assign err_o     = done_q & cmp_err;
  assign data_o    = done_q ? cmp_data : '0;
  assign fwd_vld_o = done_q & !is_last;
  assign fin_vld_o = done_q & is_last;
endmodule

// File: rtl/rq_eddr_chk.sv
module rq_eddr_chk #(
  parameter int NUM_PE = 4,
  parameter int PIX_W  = 8,
  parameter int N_PIX  = 16,
  parameter int MOD_W  = 6,
  localparam int SAD_W = PIX_W + $clog2(N_PIX),
  localparam int SEL_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
  localparam int MAX_SAD = N_PIX * ((1 << PIX_W) - 1)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic [NUM_PE-1:0][SAD_W-1:0] pe_sad_i,
  input logic [SEL_W-1:0]             sel_i,
  input logic                         done_o,
  input logic                         err_o,
  input logic [SAD_W-1:0]             data_o,
  input logic                         fwd_vld_o,
  input logic                         fin_vld_o
);
  logic sel_ok;
  assign sel_ok = int'(sel_i) < NUM_PE;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!err_o && data_o == '0 && !fwd_vld_o && !fin_vld_o));

  assert_pass_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && sel_ok) |-> (data_o == pe_sad_i[sel_i]));

  assert_flag_mismatch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o && sel_ok) |-> (data_o != pe_sad_i[sel_i]));

  assert_rebuilt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (int'(data_o) <= MAX_SAD));

  assert_route_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({fwd_vld_o, fin_vld_o}));
endmodule

bind rq_eddr rq_eddr_chk #(
  .NUM_PE(NUM_PE), .PIX_W(PIX_W), .N_PIX(N_PIX), .MOD_W(MOD_W)
) i_rq_eddr_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .pe_sad_i (pe_sad_i),
  .sel_i    (sel_i),
  .done_o   (done_o),
  .err_o    (err_o),
  .data_o   (data_o),
  .fwd_vld_o(fwd_vld_o),
  .fin_vld_o(fin_vld_o)
);

// File: tb/test_rq_eddr.sv
module test_rq_eddr;
  localparam int NP  = 4;
  localparam int NPX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                start, pvld;
  logic [NP-1:0][7:0]  cur, rf;
  logic [NP-1:0][11:0] pe_sad;
  logic [1:0]          sel;
  logic                done, err, fwd, fin;
  logic [11:0]         dout;

  rq_eddr #(.NUM_PE(NP)) i_rq_eddr (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pix_valid_i(pvld),
    .cur_pix_i(cur), .ref_pix_i(rf), .pe_sad_i(pe_sad), .sel_i(sel),
    .done_o(done), .err_o(err), .data_o(dout), .fwd_vld_o(fwd), .fin_vld_o(fin)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int unsigned cp [NP][NPX];
  int unsigned rp [NP][NPX];
  int unsigned tsad [NP];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned absd(int unsigned a, int unsigned b);
    return (a >= b) ? a - b : b - a;
  endfunction

  function automatic int unsigned stuck(int unsigned v, int unsigned sa0, int unsigned sa1);
    return ((v & ~sa0) | sa1) & 32'hfff;
  endfunction

  task automatic gen_pix(int mode);
    for (int e = 0; e < NP; e++) begin
      tsad[e] = 0;
      for (int k = 0; k < NPX; k++) begin
        case (mode)
          1: begin cp[e][k] = 255; rp[e][k] = 0; end
          2: begin cp[e][k] = $urandom % 256; rp[e][k] = cp[e][k]; end
          3: begin cp[e][k] = $urandom % 8; rp[e][k] = $urandom % 8; end
          default: begin cp[e][k] = $urandom % 256; rp[e][k] = $urandom % 256; end
        endcase
        tsad[e] += absd(cp[e][k], rp[e][k]);
      end
    end
  endtask

  // fault kinds: 0 none, 1 single sa0, 2 single sa1, 3 multi, 4 bit1 sa1 + bit11 sa0
  function automatic int unsigned fault(int unsigned v, int kind);
    int unsigned b0 = 32'd1 << ($urandom % 12);
    int unsigned b1 = 32'd1 << ($urandom % 12);
    case (kind)
      1: return stuck(v, b0, 0);
      2: return stuck(v, 0, b0);
      3: return stuck(v, $urandom & 32'hfff & $urandom, $urandom & 32'hfff & $urandom);
      4: return stuck(v, 32'h800, 32'h002);
      default: return v;
    endcase
  endfunction

  task automatic drive_pair(int k);
    for (int e = 0; e < NP; e++) begin
      cur[e] = 8'(cp[e][k]);
      rf[e]  = 8'(rp[e][k]);
    end
    pvld = 1'b1;
  endtask

  // one block: optional junk run before restart, bubbles, trailing extra pairs
  task automatic run_block(int s, int pmode, int kind_sel, int kind_oth,
                           bit bubbles, int junk, bit extra);
    bit early = 1'b0;
    int unsigned exp_sad;
    bit exp_err;
    gen_pix(pmode);
    for (int e = 0; e < NP; e++)
      pe_sad[e] = 12'(fault(tsad[e], (e == s) ? kind_sel : kind_oth));
    sel = 2'(s);
    exp_sad = tsad[s];
    exp_err = (int'(pe_sad[s]) != exp_sad);
    if (junk > 0) begin
      @(negedge clk); start = 1'b1; pvld = 1'b0;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < junk; k++) begin
        for (int e = 0; e < NP; e++) begin
          cur[e] = 8'($urandom); rf[e] = 8'($urandom);
        end
        pvld = 1'b1;
        @(negedge clk);
      end
    end
    @(negedge clk); start = 1'b1; pvld = 1'b1;
    @(negedge clk); start = 1'b0; pvld = 1'b0;
    for (int k = 0; k < NPX; k++) begin
      if (bubbles && ($urandom % 3 == 0)) begin
        pvld = 1'b0;
        @(negedge clk);
        if (done) early = 1'b1;
      end
      drive_pair(k);
      @(negedge clk);
      if (k < NPX - 1 && done) early = 1'b1;
    end
    pvld = 1'b0;
    chk(!early, "R2 early done", int'(early), 0);
    chk(done == 1'b1, "R2 done after 16th pair", int'(done), 1);
    chk(err == exp_err, "R4 error flag", int'(err), int'(exp_err));
    if (exp_err) chk(int'(dout) == exp_sad, "R6 rebuilt SAD", int'(dout), int'(exp_sad));
    else         chk(int'(dout) == exp_sad, "R5 R3 passed SAD", int'(dout), int'(exp_sad));
    chk(fin == (s == NP - 1) && fwd == (s != NP - 1), "R10 routing",
        int'({fwd, fin}), (s == NP - 1) ? 1 : 2);
    @(negedge clk);
    chk(done == 1'b0, "R2 single-cycle done", int'(done), 0);
    chk(err == 1'b0 && dout == '0 && !fwd && !fin, "R9 quiet when idle", int'(dout), 0);
    if (extra) begin
      bit extra_done = 1'b0;
      for (int k = 0; k < 4; k++) begin
        drive_pair(k);
        @(negedge clk);
        if (done) extra_done = 1'b1;
      end
      pvld = 1'b0;
      @(negedge clk);
      if (done) extra_done = 1'b1;
      chk(!extra_done, "R11 extra pairs ignored", int'(extra_done), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    start = 1'b0; pvld = 1'b0; cur = '0; rf = '0; pe_sad = '0; sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !err && dout == '0 && !fwd && !fin, "R1 reset state", int'(dout), 0);

    // R11: pairs before any start are ignored
    begin
      bit pre_done = 1'b0;
      gen_pix(0);
      for (int k = 0; k < NPX + 2; k++) begin
        drive_pair(k % NPX);
        @(negedge clk);
        if (done) pre_done = 1'b1;
      end
      pvld = 1'b0;
      chk(!pre_done, "R11 pairs before start ignored", int'(pre_done), 0);
    end

    // directed corners
    run_block(0, 0, 0, 0, 0, 0, 0);   // clean, R5
    run_block(1, 1, 1, 0, 0, 0, 0);   // max SAD with sa0, R6
    run_block(2, 2, 2, 0, 0, 0, 0);   // zero SAD with sa1, R6
    run_block(3, 0, 4, 0, 0, 0, 1);   // low sa1 + high sa0, last lane, R10 R11
    run_block(0, 1, 3, 0, 0, 0, 0);   // multi-bit on max
    run_block(1, 0, 0, 3, 0, 0, 0);   // R7: other lanes faulty, selected clean
    run_block(2, 3, 2, 0, 1, 0, 0);   // small values with bubbles
    run_block(3, 0, 1, 3, 0, 5, 0);   // R8: restart after junk pairs
    run_block(0, 0, 0, 0, 0, 15, 0);  // R8: restart one pair before completion

    for (int it = 0; it < 40; it++)
      run_block($urandom % NP, $urandom % 4, $urandom % 5, $urandom % 5,
                1'($urandom), ($urandom % 4 == 0) ? ($urandom % 16) : 0,
                ($urandom % 5 == 0));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule